// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which exception or peripheral interrupt a processor core should be running. It collects request pulses from 37 peripheral lines and seven system exception sources. It keeps a pending flag for each source and holds a stack of the handlers that are active and nested. Whenever a pending request outranks the handler in progress, the block reports an entry with the vector number to run. When the core says the current handler has finished, the block does one of two things. If a pending source beats the level underneath, it hands that source straight over as a chained entry. Otherwise it reports a return to the interrupted level.

Priorities come from a small register write port. Each peripheral and each configurable system handler has a 3-bit priority; a smaller value is more urgent. A grouping field splits that priority into a preemption part and a subpriority part. The non-maskable exception and the hard fault sit on fixed levels above every programmable one. A configurable fault that cannot be taken is turned into a hard fault.

Every output is a plain registered control pin with no handshake. An event is a one-cycle pulse, and the core is expected to act on it in that cycle. Saving processor state, fetching vectors and decoding the bus are the core's work.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset no source is pending and the nesting depth is 0. Every programmable priority is 0, every peripheral enable and every configurable-fault enable is 0, and the grouping field is 0.
- R2: Take a request sampled at clock edge E that is enabled and whose preemption level is strictly more urgent than the active level (an empty stack counts as least urgent). After edge E+1 it produces a one-cycle `evt_enter` and its vector on `evt_vec`, and the depth rises by one. Vector numbers are: system bit 0 → 2, bit 1 → 3, bit 2 → 4, bit 3 → 5, bit 4 → 6, bit 5 → 11, bit 6 → 12; peripheral line i → 16+i.
- R3: The non-maskable source (system bit 0, level -2) outranks the hard fault (system bit 1, level -1), and both outrank every programmable level. Nothing enters while the non-maskable handler is active.
- R4: If pending sources have equal full priority, the one with the lower vector number is taken first.
- R5: With grouping value g, priority bits at index g and above form the preemption level. A request whose preemption level equals the active one is not taken, even if its subpriority is better.
- R6: When several sources are pending together, the one with the more urgent full priority (preemption level, then subpriority) is taken first, even if its vector number is higher.
- R7: A request that cannot be taken stays pending. This covers a disabled peripheral and a request that does not outrank the active level. It is taken once the blocking condition goes away, and a write that enables it takes effect at the next decision.
- R8: A pending configurable fault (system bits 2 to 4) that is disabled, or that does not outrank the active level, is cleared one edge after it becomes pending and turned into a pending hard fault. The hard fault is then entered if it outranks the active level.
- R9: When `hnd_done` is high and a pending source is more urgent than the level below the finishing handler, the block pulses `evt_chain` with that source's vector after the same edge, and the depth stays the same.
- R10: In every other case, `hnd_done` pulses `evt_return` after the same edge. `evt_vec` then gives the vector of the resumed handler, or 0 for the base level, and the depth falls by one.
- R11: Vectors 7 to 10 are never reported.
- R12: Writes go through the config port. Address i (i < 37) sets peripheral i: priority from data bits 2:0, enable from bit 3. Addresses 48 to 52 set system bits 2 to 6 in the same layout; the enable is ignored for system bit 5, which is always enabled. Address 56 sets the grouping value from bits 2:0.
- R13: `hnd_done` with an empty stack has no effect.
- R14: The active stack never holds more entries than there are distinct levels, and each entry is strictly more urgent than the one below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 37 | Peripheral request pulses, one per line |
| sys_req | input | 7 | System exception request pulses (bit map in R2) |
| hnd_done | input | 1 | Current handler has finished |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address (map in R12) |
| cfg_wdata | input | 4 | Configuration data: enable in bit 3, value in bits 2:0 |
| evt_enter | output | 1 | Preempting entry pulse |
| evt_chain | output | 1 | Chained entry pulse |
| evt_return | output | 1 | Return pulse |
| evt_vec | output | 6 | Vector for the event on the pulse lines |
| act_depth | output | 4 | Number of nested active handlers |

## Verification
The bench targets ties and equal preemption levels. A comparator that uses less-or-equal would preempt a handler at the same level, or would take the higher vector on a tie. Handler completion is checked when a pending source is not more urgent than the level underneath. A design that tail-chains without comparing against that level would skip the return and hide the resumed handler. Fault escalation is exercised for a disabled fault and for a fault blocked by a more urgent handler. A missing escalation would leave the fault stuck pending and no hard fault would be entered. A disabled line enabled by a later write, a completion with an empty stack, and a reset in the middle of a nest are also checked. Getting these wrong shows up as spurious events or a stale depth.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSYS      = 7;
  localparam int SYS_NMI   = 0;
  localparam int SYS_HF    = 1;
  localparam int SYS_MEM   = 2;
  localparam int SYS_USE   = 4;
  localparam int NSET      = NSYS - 2;   // settable system handlers, index = sys bit - 2
  localparam int IRQ_VBASE = 16;
  localparam int CFG_SYS   = 48;
  localparam int CFG_GRP   = 56;
  localparam int LVL_NMI   = 1;
  localparam int LVL_HF    = 2;
  localparam int LVL_BASE  = 3;

  function automatic int sys_vec(input int idx);
    case (idx)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 5;
      4: return 6;
      5: return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/irq_arb_cfg.sv
module irq_arb_cfg
  import irq_arb_pkg::*;
#(
  parameter int NIRQ   = 37,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [PRIO_W:0]                   wdata,
  output logic [NIRQ-1:0][PRIO_W-1:0]       irq_prio,
  output logic [NIRQ-1:0]                   irq_en,
  output logic [NSET-1:0][PRIO_W-1:0]       set_prio,
  output logic [NSET-1:0]                   set_en,
  output logic [PRIO_W-1:0]                 pmask
);
  logic [PRIO_W-1:0] grp_q;
  logic [NSET-1:0]   set_en_q;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_prio[i] <= '0;
        irq_en[i]   <= 1'b0;
      end else if (we && int'(addr) == i) begin
        irq_prio[i] <= wdata[PRIO_W-1:0];
        irq_en[i]   <= wdata[PRIO_W];
      end
    end
  end

  for (genvar k = 0; k < NSET; k++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_prio[k] <= '0;
        set_en_q[k] <= 1'b0;
      end else if (we && int'(addr) == CFG_SYS + k) begin
        set_prio[k] <= wdata[PRIO_W-1:0];
        set_en_q[k] <= wdata[PRIO_W];
      end
    end
    // service call (sys bit 5) cannot be disabled
    if (k + 2 == 5) begin : g_always
      assign set_en[k] = 1'b1;
    end else begin : g_prog
      assign set_en[k] = set_en_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           grp_q <= '0;
    else if (we && int'(addr) == CFG_GRP) grp_q <= wdata[PRIO_W-1:0];
  end

  // bits at or above the grouping value belong to the preemption level
  always_comb begin
    for (int b = 0; b < PRIO_W; b++) pmask[b] = (int'(grp_q) <= b);
  end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
  parameter int NSRC   = 44,
  parameter int RANK_W = 4,
  parameter int VEC_W  = 6,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]              elig,
  input  logic [NSRC-1:0][RANK_W-1:0]  rank,
  input  logic [NSRC-1:0][RANK_W-1:0]  lvl,
  input  logic [NSRC-1:0][VEC_W-1:0]   vec,
  output logic                         win_ok,
  output logic [SRC_W-1:0]             win_idx,
  output logic [RANK_W-1:0]            win_lvl,
  output logic [VEC_W-1:0]             win_vec
);
  logic [RANK_W-1:0] best;

  // sources are ordered by ascending vector, so a strict compare keeps the lower vector on ties
  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    win_vec = '0;
    best    = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!win_ok || rank[s] < best)) begin
        win_ok  = 1'b1;
        best    = rank[s];
        win_idx = SRC_W'(s);
        win_lvl = lvl[s];
        win_vec = vec[s];
      end
    end
  end
endmodule

// File: rtl/irq_arb_stack.sv
module irq_arb_stack #(
  parameter int DEPTH  = 10,
  parameter int RANK_W = 4,
  parameter int VEC_W  = 6,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int SLOTS = 1 << CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              repl,
  input  logic [RANK_W-1:0] in_lvl,
  input  logic [VEC_W-1:0]  in_vec,
  output logic [CW-1:0]     cnt,
  output logic              empty,
  output logic [RANK_W-1:0] top_lvl,
  output logic [RANK_W-1:0] below_lvl,
  output logic [VEC_W-1:0]  below_vec
);
  logic [RANK_W-1:0] lvl_q [SLOTS];
  logic [VEC_W-1:0]  vec_q [SLOTS];
  logic [CW-1:0]     tix, bix;

  assign tix   = cnt - 1'b1;
  assign bix   = cnt - 2'd2;
  assign empty = (cnt == '0);

  always_comb begin
    top_lvl   = empty ? '1 : lvl_q[tix];
    below_lvl = (cnt < 2) ? '1 : lvl_q[bix];
    below_vec = (cnt < 2) ? '0 : vec_q[bix];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push) begin
      lvl_q[cnt] <= in_lvl;
      vec_q[cnt] <= in_vec;
      cnt        <= cnt + 1'b1;
    end else if (repl) begin
      lvl_q[tix] <= in_lvl;
      vec_q[tix] <= in_vec;
    end else if (pop) begin
      cnt <= cnt - 1'b1;
    end
  end

  a_r14_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(cnt) < DEPTH);
  a_r14_levels_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2) |-> top_lvl < below_lvl);
  a_r13_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || repl) |-> !empty);
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int NIRQ   = 37,
  parameter int PRIO_W = 3,
  localparam int NSRC   = NSYS + NIRQ,
  localparam int RANK_W = $clog2((1 << PRIO_W) + LVL_BASE + 1),
  localparam int VEC_W  = $clog2(IRQ_VBASE + NIRQ),
  localparam int ADDR_W = $clog2(CFG_GRP + 1),
  localparam int DEPTH  = (1 << PRIO_W) + 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int SRC_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NSYS-1:0]   sys_req,
  input  logic              hnd_done,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [PRIO_W:0]   cfg_wdata,
  output logic              evt_enter,
  output logic              evt_chain,
  output logic              evt_return,
  output logic [VEC_W-1:0]  evt_vec,
  output logic [CW-1:0]     act_depth
);
  logic [NIRQ-1:0][PRIO_W-1:0] irq_prio;
  logic [NIRQ-1:0]             irq_en;
  logic [NSET-1:0][PRIO_W-1:0] set_prio;
  logic [NSET-1:0]             set_en;
  logic [PRIO_W-1:0]           pmask;

  irq_arb_cfg #(.NIRQ(NIRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .irq_prio(irq_prio), .irq_en(irq_en), .set_prio(set_prio), .set_en(set_en),
    .pmask(pmask)
  );

  // per-source rank (full priority), preemption level, vector and enable
  logic [NSRC-1:0][RANK_W-1:0] rank_v, lvl_v;
  logic [NSRC-1:0][VEC_W-1:0]  vec_v;
  logic [NSRC-1:0]             en_v;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s == SYS_NMI) begin : g_nmi
      assign rank_v[s] = RANK_W'(LVL_NMI);
      assign lvl_v[s]  = RANK_W'(LVL_NMI);
      assign en_v[s]   = 1'b1;
    end else if (s == SYS_HF) begin : g_hf
      assign rank_v[s] = RANK_W'(LVL_HF);
      assign lvl_v[s]  = RANK_W'(LVL_HF);
      assign en_v[s]   = 1'b1;
    end else if (s < NSYS) begin : g_set
      assign rank_v[s] = RANK_W'(LVL_BASE) + RANK_W'(set_prio[s-2]);
      assign lvl_v[s]  = RANK_W'(LVL_BASE) + RANK_W'(set_prio[s-2] & pmask);
      assign en_v[s]   = set_en[s-2];
    end else begin : g_irq
      assign rank_v[s] = RANK_W'(LVL_BASE) + RANK_W'(irq_prio[s-NSYS]);
      assign lvl_v[s]  = RANK_W'(LVL_BASE) + RANK_W'(irq_prio[s-NSYS] & pmask);
      assign en_v[s]   = irq_en[s-NSYS];
    end
    if (s < NSYS) begin : g_svec
      assign vec_v[s] = VEC_W'(sys_vec(s));
    end else begin : g_ivec
      assign vec_v[s] = VEC_W'(IRQ_VBASE + s - NSYS);
    end
  end

  logic [NSRC-1:0]   pend_q, pend_nxt, esc, elig, clr;
  logic [RANK_W-1:0] cur_lvl, below_lvl, win_lvl;
  logic [VEC_W-1:0]  below_vec, win_vec;
  logic [SRC_W-1:0]  win_idx;
  logic              win_ok, stk_empty;
  logic              do_push, do_chain, do_pop;

  // a configurable fault that cannot be taken turns into a hard fault
  always_comb begin
    esc = '0;
    for (int s = SYS_MEM; s <= SYS_USE; s++)
      esc[s] = pend_q[s] && (!en_v[s] || lvl_v[s] >= cur_lvl);
  end

  assign elig = pend_q & en_v & ~esc;

  irq_arb_pick #(.NSRC(NSRC), .RANK_W(RANK_W), .VEC_W(VEC_W)) u_pick (
    .elig(elig), .rank(rank_v), .lvl(lvl_v), .vec(vec_v),
    .win_ok(win_ok), .win_idx(win_idx), .win_lvl(win_lvl), .win_vec(win_vec)
  );

  always_comb begin
    do_push  = 1'b0;
    do_chain = 1'b0;
    do_pop   = 1'b0;
    if (hnd_done && !stk_empty) begin
      if (win_ok && win_lvl < below_lvl) do_chain = 1'b1;
      else                               do_pop   = 1'b1;
    end else if (!hnd_done && win_ok && win_lvl < cur_lvl) begin
      do_push = 1'b1;
    end
    clr = (do_push || do_chain) ? (NSRC'(1) << win_idx) : '0;
    pend_nxt = (pend_q & ~clr & ~esc) | {irq_req, sys_req};
    pend_nxt[SYS_HF] = pend_nxt[SYS_HF] | (|esc);
  end

  irq_arb_stack #(.DEPTH(DEPTH), .RANK_W(RANK_W), .VEC_W(VEC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .repl(do_chain),
    .in_lvl(win_lvl), .in_vec(win_vec), .cnt(act_depth), .empty(stk_empty),
    .top_lvl(cur_lvl), .below_lvl(below_lvl), .below_vec(below_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      evt_enter  <= 1'b0;
      evt_chain  <= 1'b0;
      evt_return <= 1'b0;
      evt_vec    <= '0;
    end else begin
      pend_q     <= pend_nxt;
      evt_enter  <= do_push;
      evt_chain  <= do_chain;
      evt_return <= do_pop;
      evt_vec    <= (do_push || do_chain) ? win_vec : (do_pop ? below_vec : '0);
    end
  end

  a_r2_enter_deepens: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter |-> act_depth == $past(act_depth) + 1'b1);
  a_r2_enter_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter |-> cur_lvl < $past(cur_lvl));
  a_r3_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_lvl) == RANK_W'(LVL_NMI)) |-> !evt_enter);
  a_r9_chain_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chain |-> $stable(act_depth));
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_enter, evt_chain, evt_return}));
  a_r10_return_pops: assert property (@(posedge clk) disable iff (!rst_n)
    evt_return |-> act_depth == $past(act_depth) - 1'b1);
  a_r11_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_enter || evt_chain) |-> (evt_vec < 7 || evt_vec > 10));
endmodule

// File: tb/irq_nest_arb_bench.sv
`timescale 1ns/1ps
module irq_nest_arb_bench;
  localparam int NIRQ = 37;
  localparam int NROW = 63;
  // ops
  localparam int IDLE = 0, WR = 1, IRQ = 2, SYS = 3, DONE = 4;
  // expected event kind
  localparam int NONE = 0, ENT = 1, CHN = 2, RET = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [6:0]      sys_req = '0;
  logic            hnd_done = 1'b0;
  logic            cfg_we = 1'b0;
  logic [5:0]      cfg_addr = '0;
  logic [3:0]      cfg_wdata = '0;
  logic            evt_enter, evt_chain, evt_return;
  logic [5:0]      evt_vec;
  logic [3:0]      act_depth;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_nest_arb u_irq_nest_arb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sys_req(sys_req),
    .hnd_done(hnd_done), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .evt_enter(evt_enter), .evt_chain(evt_chain), .evt_return(evt_return),
    .evt_vec(evt_vec), .act_depth(act_depth)
  );

  // {op, arg, data, kind, vec, depth, req}
  function automatic logic [28:0] mk(input int op, input int a, input int d,
                                     input int k, input int v, input int dp, input int rq);
    return {3'(op), 6'(a), 4'(d), 2'(k), 6'(v), 4'(dp), 4'(rq)};
  endfunction

  localparam logic [28:0] TBL [NROW] = '{
    // R12 writes, R2 entry, R7 blocked, R10 return, R9 chain
    mk(WR, 0, 4'hB, NONE, 0, 0, 12), mk(WR, 1, 4'hB, NONE, 0, 0, 12),
    mk(WR, 2, 4'h9, NONE, 0, 0, 12), mk(IRQ, 1, 0, NONE, 0, 0, 2),
    mk(IDLE, 0, 0, ENT, 17, 1, 2),   mk(IRQ, 0, 0, NONE, 0, 1, 7),
    mk(IDLE, 0, 0, NONE, 0, 1, 7),   mk(IRQ, 2, 0, NONE, 0, 1, 2),
    mk(IDLE, 0, 0, ENT, 18, 2, 2),   mk(DONE, 0, 0, RET, 17, 1, 10),
    mk(DONE, 0, 0, CHN, 16, 1, 9),   mk(DONE, 0, 0, RET, 0, 0, 10),
    // R4 tie broken by vector
    mk(WR, 3, 4'hA, NONE, 0, 0, 12), mk(WR, 4, 4'hA, NONE, 0, 0, 12),
    mk(IRQ, 2, 0, NONE, 0, 0, 2),    mk(IDLE, 0, 0, ENT, 18, 1, 2),
    mk(IRQ, 4, 0, NONE, 0, 1, 7),    mk(IRQ, 3, 0, NONE, 0, 1, 7),
    mk(DONE, 0, 0, CHN, 19, 1, 4),   mk(DONE, 0, 0, CHN, 20, 1, 4),
    mk(DONE, 0, 0, RET, 0, 0, 10),
    // R3 non-maskable holds off priority 0
    mk(WR, 2, 4'h8, NONE, 0, 0, 12), mk(SYS, 0, 0, NONE, 0, 0, 3),
    mk(IRQ, 2, 0, ENT, 2, 1, 3),     mk(IDLE, 0, 0, NONE, 0, 1, 3),
    mk(DONE, 0, 0, CHN, 18, 1, 9),   mk(DONE, 0, 0, RET, 0, 0, 10),
    // R8 disabled fault escalates
    mk(SYS, 2, 0, NONE, 0, 0, 8),    mk(IDLE, 0, 0, NONE, 0, 0, 8),
    mk(IDLE, 0, 0, ENT, 3, 1, 8),    mk(DONE, 0, 0, RET, 0, 0, 8),
    // R5 grouping: equal preemption level does not preempt
    mk(WR, 56, 1, NONE, 0, 0, 12),   mk(WR, 5, 4'hB, NONE, 0, 0, 12),
    mk(WR, 6, 4'hA, NONE, 0, 0, 12), mk(IRQ, 5, 0, NONE, 0, 0, 5),
    mk(IDLE, 0, 0, ENT, 21, 1, 5),   mk(IRQ, 6, 0, NONE, 0, 1, 5),
    mk(IDLE, 0, 0, NONE, 0, 1, 5),   mk(DONE, 0, 0, CHN, 22, 1, 5),
    mk(DONE, 0, 0, RET, 0, 0, 10),
    // R6 subpriority beats lower vector
    mk(WR, 7, 4'h8, NONE, 0, 0, 12), mk(IRQ, 7, 0, NONE, 0, 0, 6),
    mk(IDLE, 0, 0, ENT, 23, 1, 6),   mk(IRQ, 5, 0, NONE, 0, 1, 6),
    mk(IRQ, 6, 0, NONE, 0, 1, 6),    mk(DONE, 0, 0, CHN, 22, 1, 6),
    mk(DONE, 0, 0, CHN, 21, 1, 6),   mk(DONE, 0, 0, RET, 0, 0, 10),
    // R7 disabled line waits for its enable; R13 done on empty stack
    mk(IRQ, 8, 0, NONE, 0, 0, 7),    mk(IDLE, 0, 0, NONE, 0, 0, 7),
    mk(WR, 8, 4'hF, NONE, 0, 0, 7),  mk(IDLE, 0, 0, ENT, 24, 1, 7),
    mk(DONE, 0, 0, RET, 0, 0, 10),   mk(DONE, 0, 0, NONE, 0, 0, 13),
    // R8 enabled but blocked fault escalates
    mk(WR, 49, 4'hD, NONE, 0, 0, 12), mk(IRQ, 2, 0, NONE, 0, 0, 8),
    mk(IDLE, 0, 0, ENT, 18, 1, 8),   mk(SYS, 3, 0, NONE, 0, 1, 8),
    mk(IDLE, 0, 0, NONE, 0, 1, 8),   mk(IDLE, 0, 0, ENT, 3, 2, 8),
    mk(DONE, 0, 0, RET, 18, 1, 10),  mk(DONE, 0, 0, RET, 0, 0, 10),
    mk(IDLE, 0, 0, NONE, 0, 0, 8)
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, got, exp);
    end
  endtask

  // called at a falling edge; drives one op and samples at the next falling edge
  task automatic step(input int op, input int a, input int d, input int k,
                      input int v, input int dp, input int rq);
    int gotk;
    case (op)
      WR:   begin cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 4'(d); end
      IRQ:  irq_req[a] = 1'b1;
      SYS:  sys_req[a] = 1'b1;
      DONE: hnd_done = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0; irq_req = '0; sys_req = '0; hnd_done = 1'b0;
    gotk = evt_enter ? ENT : evt_chain ? CHN : evt_return ? RET : NONE;
    check(gotk == k, rq, "event kind", gotk, k);
    if (k != NONE) check(int'(evt_vec) == v, rq, "vector", int'(evt_vec), v);
    check(int'(act_depth) == dp, rq, "depth", int'(act_depth), dp);
    if (evt_enter || evt_chain)  // R11
      check(evt_vec < 7 || evt_vec > 10, 11, "reserved vector", int'(evt_vec), 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(!evt_enter && !evt_chain && !evt_return, 1, "events after reset",
          int'({evt_enter, evt_chain, evt_return}), 0);
    check(act_depth == 0, 1, "depth after reset", int'(act_depth), 0);

    for (int r = 0; r < NROW; r++)
      step(int'(TBL[r][28:26]), int'(TBL[r][25:20]), int'(TBL[r][19:16]),
           int'(TBL[r][15:14]), int'(TBL[r][13:8]), int'(TBL[r][7:4]),
           int'(TBL[r][3:0]));

    // R14 / R3 four-deep nest: priority 7, priority 0, hard fault, non-maskable
    step(IRQ, 8, 0, NONE, 0, 0, 14);
    step(IDLE, 0, 0, ENT, 24, 1, 14);
    step(IRQ, 2, 0, NONE, 0, 1, 14);
    step(IDLE, 0, 0, ENT, 18, 2, 14);
    step(SYS, 1, 0, NONE, 0, 2, 3);
    step(IDLE, 0, 0, ENT, 3, 3, 3);
    step(SYS, 0, 0, NONE, 0, 3, 3);
    step(IDLE, 0, 0, ENT, 2, 4, 3);
    step(DONE, 0, 0, RET, 3, 3, 10);
    step(DONE, 0, 0, RET, 18, 2, 10);

    // R1 reset mid-nest with a request pending
    irq_req[8] = 1'b1;
    @(negedge clk);
    irq_req = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(act_depth == 0, 1, "depth after mid-run reset", int'(act_depth), 0);
    step(IDLE, 0, 0, NONE, 0, 0, 1);
    // enables are cleared by reset, so line 0 stays pending
    step(IRQ, 0, 0, NONE, 0, 0, 1);
    step(IDLE, 0, 0, NONE, 0, 0, 1);
    step(IDLE, 0, 0, NONE, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule